// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit and a small datapath for a 16-bit stored-program processor. It steps each instruction through a fixed set of phases. The phases are instruction fetch (F), decode (D), effective-address calculation (EA), operand fetch (OP), execute (EX) and result write (S). Each opcode visits only the phases it needs. The block holds the program counter, the instruction register and a file of eight 16-bit general registers.

The block reaches memory only through an address register and a data register. The address register drives the memory address port. A read request stays asserted until the memory answers with a ready pulse, so both the instruction fetch and the operand read tolerate any latency. The PC advances during fetch, before decode, so a jump overwrites an already-incremented value. A run enable freezes the whole machine while it is low.

Three instructions are implemented: a register add, a base-plus-offset load and a register-indirect jump. Every other opcode acts as a no-op. The register-write port is brought out as a trace, so surrounding logic can observe every result the block commits.

Top module: `icyc_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it: the PC equals the start address (default 0), the instruction register is 0, `phase_o` shows F, `mem_rd` is low, and all eight general registers are cleared to 0.
- R2: In fetch, the PC value goes to `mem_addr` first. The PC becomes PC+1 on the next cycle. Only after the memory word arrives is it copied into the instruction register. At decode, `pc_o` equals the fetch address plus one and `ir_o` equals the fetched word.
- R3: `mem_rd` stays high with a constant `mem_addr` until a cycle in which `mem_ready` is high. The word on `mem_rdata` is taken in that same cycle. Any number of wait cycles is tolerated.
- R4: Phase codes on `phase_o` are F=0, D=1, EA=2, OP=3, EX=4, S=5. The opcode is bits 15:12, the destination bits 11:9, the first source or base bits 8:6, and the second add source bits 2:0.
- R5: Add (opcode 0001) visits F, D, OP, EX, S. It writes the first source plus the second source, modulo 2^16, to the destination register.
- R6: Load (opcode 0110) visits F, D, EA, OP, S. It reads memory at the base register plus the sign-extended 6-bit offset in bits 5:0, and writes that word to the destination register.
- R7: Jump (opcode 1100) visits F, D, OP, EX. It writes no register. It loads the base register into the PC, and the next fetch uses that address.
- R8: Any other opcode visits only F and D, writes no register and makes no operand read.
- R9: While `run_en` is low, phase, PC, instruction register and registers hold, and `wb_en` stays low.
- R10: `wb_en` is high for exactly one enabled cycle per add or load, in phase S, with `wb_idx` and `wb_data` giving the destination and value. The opcode decoder produces exactly one active line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Machine advances only while high |
| mem_addr | output | 16 | Memory address register contents |
| mem_rd | output | 1 | Read request, held until `mem_ready` |
| mem_rdata | input | 16 | Word returned by memory |
| mem_ready | input | 1 | Memory word valid this cycle |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |
| phase_o | output | 3 | Current phase code |
| wb_en | output | 1 | Register write this cycle |
| wb_idx | output | 3 | Register written |
| wb_data | output | 16 | Value written |

## Verification
A wrong FSM state appears within one instruction in two ways. It breaks the phase sequence seen on `phase_o`, and it changes the PC reported at the next decode. A missing or extra phase is caught at the next return to F. A fault in the address or operand datapath first shows on `mem_addr` during the load's operand read. It then shows in the value on the write trace, a few cycles later. A jump that goes to the wrong place, or an instruction that is not skipped after the jump, shows as an out-of-order entry in the write trace. A freeze that leaks is caught in the first cycle in which `run_en` is low.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  typedef enum logic [2:0] {
    PH_F  = 3'd0,
    PH_D  = 3'd1,
    PH_EA = 3'd2,
    PH_OP = 3'd3,
    PH_EX = 3'd4,
    PH_S  = 3'd5
  } phase_e;

  typedef enum logic [3:0] {
    ST_FMAR, ST_FINC, ST_FMEM, ST_FIR,
    ST_DEC, ST_EA, ST_OP, ST_EX, ST_WR
  } state_e;

  localparam int OPC_W   = 4;
  localparam int OPC_ADD = 1;
  localparam int OPC_LDR = 6;
  localparam int OPC_JMP = 12;

endpackage

// File: rtl/icyc_decode.sv
module icyc_decode #(
  parameter int DW   = 16,
  parameter int RIW  = 3,
  parameter int OFFW = 6
) (
  input  logic [DW-1:0]                 ir,
  output logic [(1<<icyc_pkg::OPC_W)-1:0] dec_hot,
  output logic [RIW-1:0]                dst,
  output logic [RIW-1:0]                src_a,
  output logic [RIW-1:0]                src_b,
  output logic [DW-1:0]                 off_sx
);
  localparam int OW   = icyc_pkg::OPC_W;
  localparam int NOPC = 1 << OW;

  // 4-to-16 one-hot opcode lines
  for (genvar g = 0; g < NOPC; g++) begin : g_hot
    assign dec_hot[g] = (ir[DW-1 -: OW] == OW'(g));
  end

  assign dst    = ir[DW-OW-1 -: RIW];
  assign src_a  = ir[DW-OW-RIW-1 -: RIW];
  assign src_b  = ir[RIW-1:0];
  assign off_sx = {{(DW-OFFW){ir[OFFW-1]}}, ir[OFFW-1:0]};
endmodule

// File: rtl/icyc_regfile.sv
module icyc_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
endmodule

// File: rtl/icyc_core.sv
module icyc_core #(
  parameter int           DW    = 16,
  parameter int           NREG  = 8,
  parameter int           OFFW  = 6,
  parameter logic [DW-1:0] START = '0,
  localparam int          RIW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  output logic [DW-1:0]  mem_addr,
  output logic           mem_rd,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  output logic [DW-1:0]  pc_o,
  output logic [DW-1:0]  ir_o,
  output logic [2:0]     phase_o,
  output logic           wb_en,
  output logic [RIW-1:0] wb_idx,
  output logic [DW-1:0]  wb_data
);
  import icyc_pkg::*;

  localparam int NOPC = 1 << OPC_W;

  state_e        state;
  logic [DW-1:0] pc, ir, mar, mdr, opa, opb, res;

  logic [NOPC-1:0] dec_hot;
  logic [RIW-1:0]  dst, src_a, src_b;
  logic [DW-1:0]   off_sx, rd_a, rd_b;
  logic            is_add, is_ldr, is_jmp;

  icyc_decode #(.DW(DW), .RIW(RIW), .OFFW(OFFW)) dec_i (
    .ir(ir), .dec_hot(dec_hot), .dst(dst), .src_a(src_a),
    .src_b(src_b), .off_sx(off_sx)
  );

  assign is_add = dec_hot[OPC_ADD];
  assign is_ldr = dec_hot[OPC_LDR];
  assign is_jmp = dec_hot[OPC_JMP];

  icyc_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk(clk), .rst(rst), .ra_a(src_a), .ra_b(src_b),
    .rd_a(rd_a), .rd_b(rd_b), .we(wb_en), .wa(dst), .wd(wb_data)
  );

  // Memory port: request held in the two waiting states
  assign mem_addr = mar;
  assign mem_rd   = (state == ST_FMEM) || (state == ST_OP && is_ldr);

  assign wb_en   = (state == ST_WR) && run_en;
  assign wb_idx  = dst;
  assign wb_data = is_ldr ? mdr : res;

  assign pc_o = pc;
  assign ir_o = ir;

  always_comb begin
    unique case (state)
      ST_DEC:  phase_o = PH_D;
      ST_EA:   phase_o = PH_EA;
      ST_OP:   phase_o = PH_OP;
      ST_EX:   phase_o = PH_EX;
      ST_WR:   phase_o = PH_S;
      default: phase_o = PH_F;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FMAR;
      pc    <= START;
      ir    <= '0;
      mar   <= '0;
      mdr   <= '0;
      opa   <= '0;
      opb   <= '0;
      res   <= '0;
    end else if (run_en) begin
      case (state)
        ST_FMAR: begin mar <= pc;       state <= ST_FINC; end
        ST_FINC: begin pc  <= pc + 1'b1; state <= ST_FMEM; end
        ST_FMEM: if (mem_ready) begin mdr <= mem_rdata; state <= ST_FIR; end
        ST_FIR:  begin ir  <= mdr;      state <= ST_DEC;  end
        ST_DEC: begin
          if (is_ldr)                state <= ST_EA;
          else if (is_add || is_jmp) state <= ST_OP;
          else                       state <= ST_FMAR;
        end
        ST_EA: begin mar <= rd_a + off_sx; state <= ST_OP; end
        ST_OP: begin
          if (is_ldr) begin
            if (mem_ready) begin mdr <= mem_rdata; state <= ST_WR; end
          end else begin
            opa   <= rd_a;
            opb   <= rd_b;
            state <= ST_EX;
          end
        end
        ST_EX: begin
          if (is_jmp) begin pc <= opa;       state <= ST_FMAR; end
          else        begin res <= opa + opb; state <= ST_WR;   end
        end
        ST_WR:   state <= ST_FMAR;
        default: state <= ST_FMAR;
      endcase
    end
  end

  // ---- assertions ----
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == START && ir == '0 && state == ST_FMAR));

  assert_pc_early_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINC && run_en) |=> (pc == $past(pc) + 1'b1));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  assert_jump_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) |-> (is_add || is_ldr));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> ($stable(state) && $stable(pc) && $stable(ir)));

  assert_dec_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEC) |-> $onehot(dec_hot));
endmodule

// File: tb/icyc_core_tb_top.sv
module icyc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [15:0] mem_addr, mem_rdata, pc_o, ir_o, wb_data;
  logic        mem_rd, mem_ready, wb_en;
  logic [2:0]  phase_o, wb_idx;

  always #2 clk = ~clk;

  icyc_core dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc_o(pc_o), .ir_o(ir_o), .phase_o(phase_o), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // memory model with programmable latency
  logic [15:0] mem [64];
  int          lat = 0;
  int          wcnt = 0;
  assign mem_rdata = mem[mem_addr[5:0]];
  assign mem_ready = mem_rd && (wcnt >= lat);
  always @(posedge clk) wcnt <= (mem_rd && !mem_ready) ? wcnt + 1 : 0;

  int n_chk = 0, n_bad = 0;
  logic [15:0] model [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // lat[23:20], reg index[19:16], value[15:0]
  localparam logic [23:0] VEC [8] = '{
    {4'd0, 4'd1, 16'h1234}, {4'd2, 4'd2, 16'h0F0F},
    {4'd1, 4'd3, 16'h2143}, {4'd3, 4'd4, 16'hFFFF},
    {4'd0, 4'd5, 16'hFFFE}, {4'd1, 4'd6, 16'h000A},
    {4'd4, 4'd7, 16'hBEEF}, {4'd2, 4'd1, 16'hBEED}
  };

  function automatic logic [5:0] want_mask(input logic [3:0] op);
    case (op)
      4'h1:    return 6'b111011; // F D OP EX S
      4'h6:    return 6'b101111; // F D EA OP S
      4'hC:    return 6'b011011; // F D OP EX
      default: return 6'b000011; // F D
    endcase
  endfunction

  // phase / fetch / address monitor, sampled at the falling edge
  logic [5:0]  mask = '0;
  logic [2:0]  prev_ph = 3'd0;
  logic [3:0]  cur_op = '0;
  bit          op_ok = 0;
  logic [15:0] fetch_a = '0;
  bit          after_jmp = 0;
  logic [15:0] jmp_tgt = '0;

  always @(negedge clk) begin
    if (rst) begin
      mask = '0; prev_ph = 3'd0; op_ok = 0; after_jmp = 0;
    end else begin
      if (phase_o == 3'd0 && prev_ph != 3'd0 && op_ok)
        chk(mask == want_mask(cur_op), "R5/R6/R7/R8", "phase set",
            {10'd0, mask}, {10'd0, want_mask(cur_op)});
      if (phase_o == 3'd0 && prev_ph != 3'd0) mask = '0;
      mask[phase_o] = 1'b1;
      if (phase_o == 3'd0 && mem_rd && mem_ready) fetch_a = mem_addr;
      if (phase_o == 3'd1 && prev_ph != 3'd1) begin
        chk(pc_o == fetch_a + 16'd1, "R2", "pc at decode", pc_o, fetch_a + 16'd1);
        chk(ir_o == mem[fetch_a[5:0]], "R2", "ir at decode", ir_o, mem[fetch_a[5:0]]);
        if (after_jmp)
          chk(fetch_a == jmp_tgt, "R7", "fetch after jump", fetch_a, jmp_tgt);
        cur_op = ir_o[15:12];
        op_ok = 1;
        after_jmp = (ir_o[15:12] == 4'hC);
        jmp_tgt = model[ir_o[8:6]];
      end
      if (phase_o == 3'd3 && prev_ph != 3'd3 && mem_rd)
        chk(mem_addr == model[ir_o[8:6]] + {{10{ir_o[5]}}, ir_o[5:0]}, "R6",
            "effective address", mem_addr, model[ir_o[8:6]] + {{10{ir_o[5]}}, ir_o[5:0]});
      if (!run_en) chk(!wb_en, "R9", "write while frozen", {15'd0, wb_en}, 16'd0);
      prev_ph = phase_o;
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] h_pc, h_ir;
    logic [2:0]  h_ph;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++) model[i] = '0;
    mem[0]  = 16'h6214; // LDR R1,R0,#20
    mem[1]  = 16'h6415; // LDR R2,R0,#21
    mem[2]  = 16'h1642; // ADD R3,R1,R2
    mem[3]  = 16'h6816; // LDR R4,R0,#22
    mem[4]  = 16'h1B04; // ADD R5,R4,R4
    mem[5]  = 16'h6C17; // LDR R6,R0,#23
    mem[6]  = 16'hC180; // JMP R6
    mem[7]  = 16'h6E14; // skipped
    mem[9]  = 16'hBEEF;
    mem[10] = 16'h0000; // unsupported opcode
    mem[11] = 16'h6FBF; // LDR R7,R6,#-1
    mem[12] = 16'h13C5; // ADD R1,R7,R5
    mem[13] = 16'hC000; // JMP R0
    mem[20] = 16'h1234; mem[21] = 16'h0F0F;
    mem[22] = 16'hFFFF; mem[23] = 16'h000A;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(pc_o == 16'd0, "R1", "reset pc", pc_o, 16'd0);
    chk(ir_o == 16'd0, "R1", "reset ir", ir_o, 16'd0);
    chk(phase_o == 3'd0, "R1", "reset phase", {13'd0, phase_o}, 16'd0);
    chk(!mem_rd, "R1", "reset read", {15'd0, mem_rd}, 16'd0);
    repeat (4) @(negedge clk);
    chk(pc_o == 16'd0 && phase_o == 3'd0, "R9", "idle hold", pc_o, 16'd0);

    @(posedge clk); #1 run_en = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(pc_o == 16'd1, "R2", "pc incremented in fetch", pc_o, 16'd1);
    chk(ir_o == 16'd0, "R2", "ir not yet loaded", ir_o, 16'd0);

    for (int k = 0; k < 8; k++) begin
      lat = int'(VEC[k][23:20]);
      do @(negedge clk); while (!wb_en);
      chk(wb_idx == VEC[k][18:16], "R10", "write index",
          {13'd0, wb_idx}, {13'd0, VEC[k][18:16]});
      chk(wb_data == VEC[k][15:0], "R5/R6", "write value", wb_data, VEC[k][15:0]);
      model[wb_idx] = wb_data;
      @(negedge clk);
      chk(!wb_en, "R10", "single write pulse", {15'd0, wb_en}, 16'd0);
      if (k == 3) begin
        @(posedge clk); #1 run_en = 1'b0;
        h_pc = pc_o; h_ir = ir_o; h_ph = phase_o;
        repeat (6) begin
          @(negedge clk);
          chk(pc_o == h_pc && ir_o == h_ir && phase_o == h_ph, "R9",
              "frozen state", pc_o, h_pc);
        end
        @(posedge clk); #1 run_en = 1'b1;
      end
    end

    do @(negedge clk); while (!(phase_o == 3'd1 && ir_o == 16'h6214));
    chk(pc_o == 16'd1, "R7", "jump back to zero", pc_o, 16'd1);

    // reset during a stalled fetch; regs must clear
    lat = 8;
    do @(negedge clk); while (!mem_rd);
    @(posedge clk); #1 rst = 1'b1;
    mem[0] = 16'h1642; // ADD R3,R1,R2 on cleared registers
    @(posedge clk); #1 rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    @(negedge clk);
    chk(pc_o == 16'd0 && !mem_rd, "R1", "reset mid-fetch", pc_o, 16'd0);
    chk(ir_o == 16'd0, "R1", "reset ir mid-run", ir_o, 16'd0);
    lat = 0;
    do @(negedge clk); while (!wb_en);
    chk(wb_idx == 3'd3 && wb_data == 16'd0, "R1", "registers cleared", wb_data, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule